// File: doc/BRIEF.md
# SPI Controller Interrupt Flag Register

This block gathers event indications from an SPI controller and from the FIFOs on either side of it into thirteen sticky interrupt flags. Single-cycle events (mode fault, slave abort, master done, and the four FIFO misuse cases) set their flag directly. Level conditions (TX/RX threshold, TX empty, RX full) and the slave-select line set their flags on an edge, found by comparing each level with a registered copy of it. Misuse of a FIFO is split by side: a bus write into a full TX FIFO, a shift-out pull from an empty TX FIFO, a shift-in push into a full RX FIFO and a bus read from an empty RX FIFO each have a flag of their own.

Software sees two words through a small register port: the flag word at address 0, where writing a 1 to a bit clears it, and an interrupt-enable mask at address 1. One registered interrupt output is raised while any enabled flag is set. Read data is combinational from the selected register.

Top module: `spi_irq_flags`

## Requirements
- R1: After reset all flags, all mask bits and `irq` are 0, and both register addresses read 0.
- R2: A one-cycle `faultEvt`, `abortEvt` or `doneEvt` sets flag bit 6, bit 7 or bit 8 respectively, visible after the next rising clock edge.
- R3: A rising edge on `txThrLvl`, `txEmptyLvl`, `rxThrLvl` or `rxFullLvl` sets flag bit 0, 1, 2 or 3; a level that stays high sets its flag only once, so a flag cleared while its level is still high stays clear.
- R4: A rising edge of `ssActive` (select asserted) sets bit 4, a falling edge sets bit 5.
- R5: `busTxWrite` while `txFullLvl` is high sets bit 9 (TX overrun); `spiTxPull` while `txEmptyLvl` is high sets bit 10 (TX underrun); either strobe alone sets neither.
- R6: `spiRxPush` while `rxFullLvl` is high sets bit 11 (RX overrun); `busRxRead` while `rxEmptyLvl` is high sets bit 12 (RX underrun); either strobe alone sets neither.
- R7: Writing to address 0 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged; bits 15..13 of address 0 always read 0.
- R8: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Writing address 1 loads bits 12..0 of the data into the mask; reading address 1 returns the mask with bits 15..13 as 0.
- R10: `irq` is the OR of (flags AND mask), registered: it follows a change of flags or mask one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 1 | Register select: 0 flags, 1 mask |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the selected register |
| txThrLvl | input | 1 | TX FIFO at/over threshold level |
| txEmptyLvl | input | 1 | TX FIFO empty level |
| txFullLvl | input | 1 | TX FIFO full level |
| rxThrLvl | input | 1 | RX FIFO at/over threshold level |
| rxFullLvl | input | 1 | RX FIFO full level |
| rxEmptyLvl | input | 1 | RX FIFO empty level |
| ssActive | input | 1 | Slave select, 1 when asserted |
| faultEvt | input | 1 | Multi-master mode fault pulse |
| abortEvt | input | 1 | Slave abort pulse |
| doneEvt | input | 1 | Master transaction finished pulse |
| busTxWrite | input | 1 | Bus side writes the TX FIFO |
| spiTxPull | input | 1 | Shifter pulls from the TX FIFO |
| spiRxPush | input | 1 | Shifter pushes into the RX FIFO |
| busRxRead | input | 1 | Bus side reads the RX FIFO |
| irq | output | 1 | Combined masked interrupt |

## Verification
A flag register stuck, wrongly cleared or set by the wrong event shows at the ports the cycle after the event, as a wrong value on a read of address 0, so every stimulus is followed by a read one edge later. A stale level copy shows as a missing flag on the first edge or as a second setting while the level stays high, which the clear-while-high test exposes. A wrong mask or interrupt register shows on `irq` exactly one edge after the flag or mask changes, so `irq` is sampled both before and after that edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NUM_FLAGS  = 13;
  localparam int NUM_LEVELS = 5;

  // flag bit positions (software decodes these)
  localparam int FL_TX_THR   = 0;
  localparam int FL_TX_EMPTY = 1;
  localparam int FL_RX_THR   = 2;
  localparam int FL_RX_FULL  = 3;
  localparam int FL_SS_ON    = 4;
  localparam int FL_SS_OFF   = 5;
  localparam int FL_FAULT    = 6;
  localparam int FL_ABORT    = 7;
  localparam int FL_DONE     = 8;
  localparam int FL_TX_OVR   = 9;
  localparam int FL_TX_UNDR  = 10;
  localparam int FL_RX_OVR   = 11;
  localparam int FL_RX_UNDR  = 12;

  // positions inside the level vector watched for edges
  localparam int LV_TX_THR   = 0;
  localparam int LV_TX_EMPTY = 1;
  localparam int LV_RX_THR   = 2;
  localparam int LV_RX_FULL  = 3;
  localparam int LV_SS       = 4;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setVec;
    logic [NUM_FLAGS-1:0] clrVec;
    logic                 maskWr;
  } flag_strobe_t;
endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regAddr,
  input  logic                 regWrEn,
  input  logic [NUM_FLAGS-1:0] wrBits,
  input  logic                 txThrLvl,
  input  logic                 txEmptyLvl,
  input  logic                 txFullLvl,
  input  logic                 rxThrLvl,
  input  logic                 rxFullLvl,
  input  logic                 rxEmptyLvl,
  input  logic                 ssActive,
  input  logic                 faultEvt,
  input  logic                 abortEvt,
  input  logic                 doneEvt,
  input  logic                 busTxWrite,
  input  logic                 spiTxPull,
  input  logic                 spiRxPush,
  input  logic                 busRxRead,
  output flag_strobe_t         strobe
);
  logic [NUM_LEVELS-1:0] levelNow;
  logic [NUM_LEVELS-1:0] levelQ;
  logic [NUM_LEVELS-1:0] levelRise;
  logic [NUM_LEVELS-1:0] levelFall;

  always_comb begin
    levelNow              = '0;
    levelNow[LV_TX_THR]   = txThrLvl;
    levelNow[LV_TX_EMPTY] = txEmptyLvl;
    levelNow[LV_RX_THR]   = rxThrLvl;
    levelNow[LV_RX_FULL]  = rxFullLvl;
    levelNow[LV_SS]       = ssActive;
  end

  // one edge detector per watched level
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : gEdge
    always_ff @(posedge clk) begin
      if (!rstN) levelQ[g] <= 1'b0;
      else       levelQ[g] <= levelNow[g];
    end
    assign levelRise[g] = levelNow[g] & ~levelQ[g];
    assign levelFall[g] = ~levelNow[g] & levelQ[g];
  end

  always_comb begin
    strobe                     = '0;
    strobe.setVec[FL_TX_THR]   = levelRise[LV_TX_THR];
    strobe.setVec[FL_TX_EMPTY] = levelRise[LV_TX_EMPTY];
    strobe.setVec[FL_RX_THR]   = levelRise[LV_RX_THR];
    strobe.setVec[FL_RX_FULL]  = levelRise[LV_RX_FULL];
    strobe.setVec[FL_SS_ON]    = levelRise[LV_SS];
    strobe.setVec[FL_SS_OFF]   = levelFall[LV_SS];
    strobe.setVec[FL_FAULT]    = faultEvt;
    strobe.setVec[FL_ABORT]    = abortEvt;
    strobe.setVec[FL_DONE]     = doneEvt;
    strobe.setVec[FL_TX_OVR]   = busTxWrite & txFullLvl;
    strobe.setVec[FL_TX_UNDR]  = spiTxPull & txEmptyLvl;
    strobe.setVec[FL_RX_OVR]   = spiRxPush & rxFullLvl;
    strobe.setVec[FL_RX_UNDR]  = busRxRead & rxEmptyLvl;
    strobe.clrVec              = (regWrEn && !regAddr) ? wrBits : '0;
    strobe.maskWr              = regWrEn && regAddr;
  end
endmodule

// File: rtl/spi_irq_datapath.sv
module spi_irq_datapath
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  flag_strobe_t         strobe,
  input  logic                 regAddr,
  input  logic [NUM_FLAGS-1:0] wrBits,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic [NUM_FLAGS-1:0] maskQ,
  output logic                 irqQ
);
  localparam int PAD_W = DATA_W - NUM_FLAGS;

  // sticky flags: a set in the same cycle beats a clear
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN) flagQ[g] <= 1'b0;
      else       flagQ[g] <= strobe.setVec[g] | (flagQ[g] & ~strobe.clrVec[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              maskQ <= '0;
    else if (strobe.maskWr) maskQ <= wrBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(flagQ & maskQ);
  end

  logic [NUM_FLAGS-1:0] selWord;
  assign selWord = regAddr ? maskQ : flagQ;

  if (PAD_W > 0) begin : gPad
    assign rdData = {{PAD_W{1'b0}}, selWord};
  end else begin : gNoPad
    assign rdData = selWord;
  end
endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txThrLvl,
  input  logic              txEmptyLvl,
  input  logic              txFullLvl,
  input  logic              rxThrLvl,
  input  logic              rxFullLvl,
  input  logic              rxEmptyLvl,
  input  logic              ssActive,
  input  logic              faultEvt,
  input  logic              abortEvt,
  input  logic              doneEvt,
  input  logic              busTxWrite,
  input  logic              spiTxPull,
  input  logic              spiRxPush,
  input  logic              busRxRead,
  output logic              irq
);
  flag_strobe_t         strobe;
  logic [NUM_FLAGS-1:0] wrBits;
  logic [NUM_FLAGS-1:0] flagVec;
  logic [NUM_FLAGS-1:0] maskVec;

  assign wrBits = regWrData[NUM_FLAGS-1:0];

  if (DATA_W > NUM_FLAGS) begin : gHi
    logic unusedHiBits;
    assign unusedHiBits = ^regWrData[DATA_W-1:NUM_FLAGS];
  end

  spi_irq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .wrBits     (wrBits),
    .txThrLvl   (txThrLvl),
    .txEmptyLvl (txEmptyLvl),
    .txFullLvl  (txFullLvl),
    .rxThrLvl   (rxThrLvl),
    .rxFullLvl  (rxFullLvl),
    .rxEmptyLvl (rxEmptyLvl),
    .ssActive   (ssActive),
    .faultEvt   (faultEvt),
    .abortEvt   (abortEvt),
    .doneEvt    (doneEvt),
    .busTxWrite (busTxWrite),
    .spiTxPull  (spiTxPull),
    .spiRxPush  (spiRxPush),
    .busRxRead  (busRxRead),
    .strobe     (strobe)
  );

  spi_irq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regAddr (regAddr),
    .wrBits  (wrBits),
    .rdData  (regRdData),
    .flagQ   (flagVec),
    .maskQ   (maskVec),
    .irqQ    (irq)
  );
endmodule

// File: rtl/spi_irq_flags_chk.sv
module spi_irq_flags_chk
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regAddr,
  input logic                 regWrEn,
  input logic [DATA_W-1:0]    regWrData,
  input logic                 faultEvt,
  input logic                 doneEvt,
  input logic                 ssActive,
  input logic                 busTxWrite,
  input logic                 txFullLvl,
  input logic                 spiRxPush,
  input logic                 rxFullLvl,
  input logic [NUM_FLAGS-1:0] flagVec,
  input logic [NUM_FLAGS-1:0] maskVec,
  input logic                 irq
);
  logic clrWrite;
  assign clrWrite = regWrEn && !regAddr;

  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    faultEvt |=> flagVec[FL_FAULT]);  // R2
  AST_SS_ASSERT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssActive) |=> flagVec[FL_SS_ON]);  // R4
  AST_SS_DEASSERT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssActive) |=> flagVec[FL_SS_OFF]);  // R4
  AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (busTxWrite && txFullLvl) |=> flagVec[FL_TX_OVR]);  // R5
  AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (spiRxPush && rxFullLvl) |=> flagVec[FL_RX_OVR]);  // R6
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (flagVec[FL_FAULT] && !(clrWrite && regWrData[FL_FAULT])) |=> flagVec[FL_FAULT]);  // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (doneEvt && clrWrite && regWrData[FL_DONE]) |=> flagVec[FL_DONE]);  // R8
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (|(flagVec & maskVec)) |=> irq);  // R10
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !(|(flagVec & maskVec)) |=> !irq);  // R10
endmodule

bind spi_irq_flags spi_irq_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .faultEvt   (faultEvt),
  .doneEvt    (doneEvt),
  .ssActive   (ssActive),
  .busTxWrite (busTxWrite),
  .txFullLvl  (txFullLvl),
  .spiRxPush  (spiRxPush),
  .rxFullLvl  (rxFullLvl),
  .flagVec    (flagVec),
  .maskVec    (maskVec),
  .irq        (irq)
);

// File: tb/spi_irq_flags_bench.sv
module spi_irq_flags_bench;
  localparam int DW = 16;

  // stimulus bit positions
  localparam int S_TXTHR = 0,  S_TXEMP = 1,  S_TXFUL = 2,  S_RXTHR = 3;
  localparam int S_RXFUL = 4,  S_RXEMP = 5,  S_SS    = 6,  S_FAULT = 7;
  localparam int S_ABORT = 8,  S_DONE  = 9,  S_BTXW  = 10, S_STXP  = 11;
  localparam int S_SRXP  = 12, S_BRXR  = 13;
  localparam int NVEC = 15;

  // {req, stim, expected flags}
  typedef struct packed {
    logic [7:0]  req;
    logic [13:0] stim;
    logic [15:0] expect_;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'd2,  14'(1 << S_FAULT), 16'h0040},                     // R2
    '{8'd2,  14'(1 << S_ABORT), 16'h0080},                     // R2
    '{8'd2,  14'(1 << S_DONE),  16'h0100},                     // R2
    '{8'd3,  14'(1 << S_TXTHR), 16'h0001},                     // R3
    '{8'd3,  14'(1 << S_TXEMP), 16'h0002},                     // R3
    '{8'd3,  14'(1 << S_RXTHR), 16'h0004},                     // R3
    '{8'd3,  14'(1 << S_RXFUL), 16'h0008},                     // R3
    '{8'd4,  14'(1 << S_SS),    16'h0030},                     // R4 rise then fall
    '{8'd5,  14'(1 << S_BTXW),  16'h0000},                     // R5 no full
    '{8'd5,  14'((1 << S_BTXW) | (1 << S_TXFUL)), 16'h0200},   // R5
    '{8'd5,  14'((1 << S_STXP) | (1 << S_TXEMP)), 16'h0402},   // R5
    '{8'd6,  14'((1 << S_SRXP) | (1 << S_RXFUL)), 16'h0808},   // R6
    '{8'd6,  14'((1 << S_BRXR) | (1 << S_RXEMP)), 16'h1000},   // R6
    '{8'd6,  14'(1 << S_BRXR),  16'h0000},                     // R6 no empty
    '{8'd2,  14'((1 << S_FAULT) | (1 << S_DONE)), 16'h0140}    // R2
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regAddr = 1'b0;
  logic regWrEn = 1'b0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic [13:0] stim = '0;
  logic irq;
  int totalChecks = 0;
  int failChecks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_irq_flags #(.DATA_W(DW)) u_spi_irq_flags (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .txThrLvl   (stim[S_TXTHR]),
    .txEmptyLvl (stim[S_TXEMP]),
    .txFullLvl  (stim[S_TXFUL]),
    .rxThrLvl   (stim[S_RXTHR]),
    .rxFullLvl  (stim[S_RXFUL]),
    .rxEmptyLvl (stim[S_RXEMP]),
    .ssActive   (stim[S_SS]),
    .faultEvt   (stim[S_FAULT]),
    .abortEvt   (stim[S_ABORT]),
    .doneEvt    (stim[S_DONE]),
    .busTxWrite (stim[S_BTXW]),
    .spiTxPull  (stim[S_STXP]),
    .spiRxPush  (stim[S_SRXP]),
    .busRxRead  (stim[S_BRXR]),
    .irq        (irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    totalChecks++;
    if (act !== exp) begin
      failChecks++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic addr, input logic [DW-1:0] data);
    regAddr = addr; regWrEn = 1'b1; regWrData = data;
    tick();
    regWrEn = 1'b0; regWrData = '0; regAddr = 1'b0;
  endtask

  task automatic readFlags(output logic [DW-1:0] v);
    regAddr = 1'b0;
    #1 v = regRdData;
  endtask

  initial begin
    logic [DW-1:0] rv;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    readFlags(rv);
    check("R1 flags", rv, 16'h0000);
    regAddr = 1'b1; #1 check("R1 mask", regRdData, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
    regAddr = 1'b0;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      regWrite(1'b0, 16'hFFFF);
      stim = VECS[i].stim;
      tick();
      stim = '0;
      tick();
      readFlags(rv);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), rv, VECS[i].expect_);
    end
    regWrite(1'b0, 16'hFFFF);

    // R7 selective clear, zero write, upper bits
    stim[S_FAULT] = 1'b1; stim[S_ABORT] = 1'b1;
    tick();
    stim = '0;
    regWrite(1'b0, 16'h0040);
    readFlags(rv);
    check("R7 partial clear", rv, 16'h0080);
    regWrite(1'b0, 16'h0000);
    readFlags(rv);
    check("R7 zero write", rv, 16'h0080);
    regWrite(1'b0, 16'hE000);
    readFlags(rv);
    check("R7 upper bits", rv, 16'h0080);
    regWrite(1'b0, 16'hFFFF);

    // R3 level held high does not re-set after clear
    stim[S_TXTHR] = 1'b1;
    tick();
    regWrite(1'b0, 16'h0001);
    tick(); tick();
    readFlags(rv);
    check("R3 held level", rv, 16'h0000);
    stim = '0;
    tick();

    // R8 set wins over same-cycle clear
    regAddr = 1'b0; regWrEn = 1'b1; regWrData = 16'h0100;
    stim[S_DONE] = 1'b1;
    tick();
    regWrEn = 1'b0; regWrData = '0; stim = '0;
    readFlags(rv);
    check("R8 set wins", rv, 16'h0100);
    regWrite(1'b0, 16'hFFFF);

    // R9 mask readback
    regWrite(1'b1, 16'hFFFF);
    regAddr = 1'b1; #1 check("R9 mask", regRdData, 16'h1FFF);
    regAddr = 1'b0;

    // R10 irq latency
    check("R10 irq idle", {15'd0, irq}, 16'h0000);
    stim[S_FAULT] = 1'b1;
    tick();
    stim = '0;
    check("R10 irq before", {15'd0, irq}, 16'h0000);
    tick();
    check("R10 irq after", {15'd0, irq}, 16'h0001);
    regWrite(1'b1, 16'h0000);
    check("R10 irq mask off lag", {15'd0, irq}, 16'h0001);
    tick();
    check("R10 irq masked", {15'd0, irq}, 16'h0000);
    regWrite(1'b0, 16'hFFFF);

    finished = 1'b1;
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      totalChecks++;
      failChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
      $finish;
    end
  end
endmodule